// File: doc/BRIEF.md
# Five-Digit Sequence Lock

This block watches a stream of keypad entries and opens a lock once the digits one, two, three, four and five have arrived in that order. Each entry is a ten-bit vector with one line per digit, qualified by a strobe. The strobe marks the single cycle in which a key is taken. Between strobes the machine keeps its position in the sequence.

The machine has six positions: idle, four partial-match positions and the open position. A key of digit one always restarts the match at the first position, so an entry such as 1,1,2,3,4,5 or 1,2,3,1,2,3,4,5 still opens the lock. Any other wrong key sends the machine back to idle. A key vector with no line set or with several lines set counts as wrong. The open output is a pure function of the registered position. It stays high until the next accepted key.

Top module: `combo_lock`

## Requirements
- R1: While rst_n is low at a rising clock edge, the machine enters idle, and unlock reads 0 after that edge.
- R2: In any cycle where key_vld is low, the position does not change, whatever key_lines carries.
- R3: An accepted key in which only key_lines[1] is set (digit 1) moves the machine to the first partial-match position from every position, including open.
- R4: An accepted key whose single set line matches the next code digit advances one position. The matches are digit 2 after one match, 3 after two, 4 after three and 5 after four. After the fifth correct key the machine is open.
- R5: An accepted key whose single set line is neither digit 1 nor the next expected digit returns the machine to idle.
- R6: An accepted key with zero lines set, or with two or more lines set, is treated as a wrong key and returns the machine to idle.
- R7: unlock is 1 exactly while the machine is in the open position. It changes only on a clock edge following an accepted key or reset, never directly from the current inputs.
- R8: From open, the next accepted key always drops unlock. Digit 1 goes to the first match position, and any other key goes to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| key_vld | input | 1 | Key strobe; key_lines is taken only when high |
| key_lines | input | 10 | One line per digit; bit k set means digit k |
| unlock | output | 1 | High while the lock is open |

## Verification
The embedded assertions cover the local transition rules on every cycle:
- reset lands in idle;
- a low strobe freezes the position;
- a digit-one key lands in the first match position;
- a malformed key vector lands in idle;
- an accepted key always closes an open lock;
- unlock only rises after an accepted key.

Whether whole digit sequences open the lock is visible only in the bench's scenarios. This covers overlapping restarts, wrong digits mid-sequence, malformed keys just before the final digit, and strobe-low noise between keys.

// File: rtl/combo_lock_pkg.sv
// Package: shared types and constants for the sequence lock.
// Assumes the code is the ascending run 1..5 over a decimal keypad.
package combo_lock_pkg;

    localparam int KEY_COUNT = 10;
    localparam int DIGIT_W   = $clog2(KEY_COUNT);

    // Match positions, in sequence order; the order is relied on to advance
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_M1   = 3'd1,
        ST_M2   = 3'd2,
        ST_M3   = 3'd3,
        ST_M4   = 3'd4,
        ST_OPEN = 3'd5
    } lock_state_t;

    // Digit expected to reach position idx+1 from position idx
    function automatic logic [DIGIT_W-1:0] code_digit(input int idx);
        return DIGIT_W'(idx + 1);
    endfunction

endpackage

// File: rtl/combo_lock_key_decode.sv
// Key decoder: turns the one-line-per-digit vector into a binary digit
// plus a flag saying exactly one line was set.
// Assumes nothing about the vector; malformed input yields single=0.
module combo_lock_key_decode #(
    parameter int KEYS = 10,
    parameter int DW   = $clog2(KEYS)
) (
    input  logic [KEYS-1:0] lines,
    output logic [DW-1:0]   digit,
    output logic            single
);

    // Purpose: OR-encode the set line index and count the set lines
    always_comb begin
        digit = '0;
        for (int i = 0; i < KEYS; i++) begin
            if (lines[i]) digit = digit | DW'(i);
        end
        single = ($countones(lines) == 1);
    end

endmodule

// File: rtl/combo_lock_next_state.sv
// Transition function of the lock.
// Assumes digit is meaningful only when single is high.
module combo_lock_next_state
    import combo_lock_pkg::*;
(
    input  lock_state_t          cur,
    input  logic                 key_vld,
    input  logic [DIGIT_W-1:0]   digit,
    input  logic                 single,
    output lock_state_t          nxt
);

    logic in_progress;

    // Purpose: flag the positions from which a correct digit advances
    always_comb begin
        in_progress = (cur != ST_IDLE) && (cur != ST_OPEN);
    end

    // Purpose: pick the next position from the current one and the key
    always_comb begin
        nxt = cur;
        if (key_vld) begin
            if (!single) begin
                nxt = ST_IDLE;
            end else if (digit == code_digit(0)) begin
                nxt = ST_M1;
            end else if (in_progress && digit == code_digit(int'(cur))) begin
                nxt = lock_state_t'(3'(cur) + 3'd1);
            end else begin
                nxt = ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/combo_lock_out.sv
// Output function: the lock is open only in the final position.
// Assumes a registered state input, so the output is glitch-free per cycle.
module combo_lock_out
    import combo_lock_pkg::*;
(
    input  lock_state_t state,
    output logic        open
);

    // Purpose: decode the open position
    always_comb begin
        open = (state == ST_OPEN);
    end

endmodule

// File: rtl/combo_lock.sv
// Top of the five-digit sequence lock: decoder, transition logic,
// state register and output decode.
// Assumes key_lines is sampled only in cycles where key_vld is high.
module combo_lock
    import combo_lock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 key_vld,
    input  logic [KEY_COUNT-1:0] key_lines,
    output logic                 unlock
);

    logic [DIGIT_W-1:0] key_digit;
    logic               key_single;
    lock_state_t        state_q;
    lock_state_t        state_d;

    combo_lock_key_decode #(
        .KEYS (KEY_COUNT),
        .DW   (DIGIT_W)
    ) dec_i (
        .lines  (key_lines),
        .digit  (key_digit),
        .single (key_single)
    );

    combo_lock_next_state ns_i (
        .cur     (state_q),
        .key_vld (key_vld),
        .digit   (key_digit),
        .single  (key_single),
        .nxt     (state_d)
    );

    // Purpose: hold the current position, cleared by synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    combo_lock_out out_i (
        .state (state_q),
        .open  (unlock)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_IDLE) && !unlock);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_vld |=> $stable(state_q));

    // R3
    digit_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_vld && key_lines == 10'b00_0000_0010) |=> state_q == ST_M1);

    // R6
    malformed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_vld && $countones(key_lines) != 1) |=> state_q == ST_IDLE);

    // R7
    rise_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock) |-> $past(key_vld));

    // R8
    close_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock && key_vld) |=> !unlock);

endmodule

// File: tb/combo_lock_tb_top.sv
`timescale 1ns/1ps
module combo_lock_tb_top;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_vld = 1'b0;
    logic [9:0] key_lines = '0;
    logic       unlock;

    int total = 0;
    int bad = 0;
    int prog = 0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    combo_lock dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_vld   (key_vld),
        .key_lines (key_lines),
        .unlock    (unlock)
    );

    function automatic logic [9:0] dg(input int d);
        return 10'(1) << d;
    endfunction

    // Reference progress from the requirements (R3, R4, R5, R6)
    function automatic void model_key(input logic [9:0] l);
        int d;
        if ($countones(l) != 1) begin
            prog = 0;
            return;
        end
        d = 0;
        for (int i = 0; i < 10; i++) if (l[i]) d = i;
        if (d == 1) prog = 1;
        else if (prog >= 1 && prog <= 4 && d == prog + 1) prog = prog + 1;
        else prog = 0;
    endfunction

    task automatic press(input logic [9:0] l, input string tag);
        @(negedge clk);
        key_vld = 1'b1;
        key_lines = l;
        model_key(l);
        sb.push_back('{exp: (prog == 5), tag: tag});
    endtask

    task automatic idle(input int n, input logic [9:0] l, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            key_vld = 1'b0;
            key_lines = l;
            sb.push_back('{exp: (prog == 5), tag: tag});
        end
    endtask

    task automatic press_seq(input int a, input int b, input int c,
                             input int d, input int e, input string tag);
        press(dg(a), tag);
        press(dg(b), tag);
        press(dg(c), tag);
        press(dg(d), tag);
        press(dg(e), tag);
    endtask

    task automatic check_now(input logic exp, input string tag);
        total++;
        if (unlock !== exp) begin
            bad++;
            $display("FAIL %s unlock=%0b expected=%0b", tag, unlock, exp);
        end
    endtask

    // Monitor: compare each cycle's result after the edge that applies it
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check_now(it.exp, it.tag);
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog unlock=%0b expected=done", unlock);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic drain;
        idle(1, '0, "drain");
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        key_vld = 1'b0;
        prog = 0;
        @(negedge clk);
        check_now(1'b0, "R1 reset");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_now(1'b0, "R1 initial reset");
        rst_n = 1'b1;

        // R4: the plain code opens
        press_seq(1, 2, 3, 4, 5, "R4 code");
        // R2 / R7: strobe low with noise keeps it open
        idle(3, 10'h3FF, "R2 R7 hold open");
        // R8: wrong key from open closes to idle
        press(dg(7), "R8 close to idle");
        press_seq(2, 3, 4, 5, 5, "R8 idle stays shut");
        // R8 + R3: digit 1 from open restarts
        press_seq(1, 2, 3, 4, 5, "R4 reopen");
        press(dg(1), "R8 R3 one from open");
        press(dg(2), "R3 follow");
        press(dg(3), "R3 follow");
        press(dg(4), "R3 follow");
        press(dg(5), "R3 opens after restart");
        drain();
        do_reset();

        // R3: repeated one
        press(dg(1), "R3 first one");
        press_seq(1, 2, 3, 4, 5, "R3 double one");
        // R3: restart mid-sequence
        press(dg(9), "R8 leave");
        press(dg(1), "R3 a");
        press(dg(2), "R3 a");
        press(dg(3), "R3 a");
        press_seq(1, 2, 3, 4, 5, "R3 overlap");
        // R5: wrong digit mid-sequence
        press(dg(0), "R8 leave");
        press(dg(1), "R5 a");
        press(dg(2), "R5 a");
        press(dg(9), "R5 wrong digit");
        press(dg(3), "R5 after wrong");
        press(dg(4), "R5 after wrong");
        press(dg(5), "R5 no open");
        // R5: skipped digit
        press_seq(1, 2, 4, 5, 5, "R5 skip");
        // R6: two lines set just before the last digit
        press(dg(1), "R6 a");
        press(dg(2), "R6 a");
        press(dg(3), "R6 a");
        press(dg(4), "R6 a");
        press(dg(4) | dg(5), "R6 two lines");
        press(dg(5), "R6 no open");
        // R6: zero lines set
        press(dg(1), "R6 b");
        press(dg(2), "R6 b");
        press(dg(3), "R6 b");
        press(dg(4), "R6 b");
        press('0, "R6 empty key");
        press(dg(5), "R6 no open empty");
        // R2: noise while strobe low mid-sequence
        press(dg(1), "R2 a");
        press(dg(2), "R2 a");
        idle(2, dg(9), "R2 ignore nine");
        idle(1, '0, "R2 ignore empty");
        press(dg(3), "R2 a");
        press(dg(4), "R2 a");
        idle(2, dg(1), "R2 ignore one");
        press(dg(5), "R2 opens");
        drain();
        // R1: reset while open
        do_reset();
        idle(2, '0, "R1 stays shut");
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule